// File: doc/BRIEF.md
# Operand Address Normaliser

This block turns the two raw operands of a fetched instruction into values that an execute stage can use directly. Each operand carries a 2-bit mode. An immediate operand passes through as data. Every other mode produces an absolute core address. The core is circular: all address arithmetic wraps modulo the `CORE_SIZE` parameter, so an offset of zero names the instruction's own location.

The indirect modes read a pointer word through a single memory port. The pointer taken from that word is the B-field of the intermediate location. In predecrement mode the block lowers that B-field by one and writes it back before using it. Operand A is always finished, including any write-back, before operand B starts. This ordering makes A's side effect on core visible to B.

A one-cycle `start` pulse launches a job. The job takes between two and four cycles, depending on the two modes. A one-cycle `done` pulse then presents both results together.

Top module: `operand_normaliser`

## Requirements
- R1: While reset is held, and after it is released until the first `start`, `done`, `busy`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: Mode 2'b00 (immediate) gives a result equal to the raw operand and sets its immediate flag to 1. It makes no memory access and costs one cycle.
- R3: Mode 2'b01 (direct) gives (pc + raw) mod CORE_SIZE with the immediate flag at 0. It makes no memory access and costs one cycle.
- R4: Mode 2'b10 (indirect) reads at (pc + raw) mod CORE_SIZE in the operand's first cycle. The read data arrives one cycle after `mem_rd_en`. The result is (pc + read data) mod CORE_SIZE, no write is made, and the mode costs two cycles.
- R5: Mode 2'b11 (predecrement) reads like R4. In the second cycle it writes (read data − 1) mod CORE_SIZE to the same address, so 0 becomes CORE_SIZE−1. The result is pc plus that decremented value, mod CORE_SIZE. A read and a write never occur in the same cycle.
- R6: Every memory access for operand A comes before any access for operand B. B's read observes A's write-back.
- R7: `done` is high for exactly one cycle. It rises N cycles after the clock edge that samples `start`, where N is the sum of the two operands' costs. `out_a`, `out_b`, `imm_a` and `imm_b` hold their values from that pulse until the next pulse.
- R8: `start` is ignored while `busy` is 1. A job in progress keeps its latched inputs, memory trace and results.
- R9: Every address sum and decrement wraps modulo CORE_SIZE. Non-immediate results are always below CORE_SIZE. Raw operands and read data are assumed to be below CORE_SIZE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a job with the current inputs (ignored while busy) |
| pc | input | AW | Address of the instruction being normalised |
| mode_a | input | 2 | Mode of operand A (00 imm, 01 direct, 10 indirect, 11 predecrement) |
| raw_a | input | AW | Raw value of operand A |
| mode_b | input | 2 | Mode of operand B |
| raw_b | input | AW | Raw value of operand B |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse: results valid |
| out_a | output | AW | Normalised operand A |
| imm_a | output | 1 | Operand A is immediate data |
| out_b | output | AW | Normalised operand B |
| imm_b | output | 1 | Operand B is immediate data |
| mem_rd_en | output | 1 | Core read request |
| mem_wr_en | output | 1 | Core write request |
| mem_addr | output | AW | Core address for read or write |
| mem_wdata | output | AW | Decremented B-field to write back |
| mem_rdata | input | AW | B-field read, valid the cycle after the request |

## Verification
Counting from the clock edge that samples `start`:
- Operand A's memory requests appear in cycle 0, or in cycles 0 and 1 for the indirect modes.
- Operand B's requests follow directly after A's.
- `done` and both results appear after a further edge, N cycles in, where N is the summed operand cost.

The bench builds, per job, an expected per-cycle list of read, write, address and write data from its own model of core. It compares that list at each falling edge, then checks `done` and the results at cycle N and their hold at cycle N+1.

// File: rtl/norm_pkg.sv
package norm_pkg;
  typedef enum logic [1:0] {
    MODE_IMM = 2'b00,
    MODE_DIR = 2'b01,
    MODE_IND = 2'b10,
    MODE_PRE = 2'b11
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_A_ADDR,
    ST_A_DATA,
    ST_B_ADDR,
    ST_B_DATA
  } nstate_e;

  // an operand mode needs a core read when its upper bit is set
  function automatic logic mode_reads(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/norm_eval.sv
module norm_eval
  import norm_pkg::*;
#(
  parameter int CORE_SIZE = 8000,
  localparam int AW = $clog2(CORE_SIZE)
) (
  input  logic [AW-1:0] pc,
  input  amode_e        mode,
  input  logic [AW-1:0] raw,
  input  logic [AW-1:0] rdata,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] dec_word,
  output logic [AW-1:0] result,
  output logic          is_imm
);
  localparam logic [AW:0]   N_EXT  = (AW+1)'(CORE_SIZE);
  localparam logic [AW-1:0] N_LAST = AW'(CORE_SIZE - 1);

  // circular sum of two in-range values
  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] x, input logic [AW-1:0] y);
    logic [AW:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= N_EXT) s = s - N_EXT;
    return s[AW-1:0];
  endfunction

  // circular decrement: zero steps back to the last location
  function automatic logic [AW-1:0] wrap_dec(input logic [AW-1:0] x);
    return (x == '0) ? N_LAST : x - 1'b1;
  endfunction

  always_comb begin
    ptr      = wrap_add(pc, raw);
    dec_word = wrap_dec(rdata);
    is_imm   = (mode == MODE_IMM);
    unique case (mode)
      MODE_IMM: result = raw;
      MODE_DIR: result = ptr;
      MODE_IND: result = wrap_add(pc, rdata);
      default:  result = wrap_add(pc, dec_word);
    endcase
  end
endmodule

// File: rtl/norm_ctrl.sv
module norm_ctrl
  import norm_pkg::*;
#(
  parameter int CORE_SIZE = 8000,
  localparam int AW = $clog2(CORE_SIZE)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [AW-1:0]       pc_in,
  input  logic [1:0]          mode_a_in,
  input  logic [AW-1:0]       raw_a_in,
  input  logic [1:0]          mode_b_in,
  input  logic [AW-1:0]       raw_b_in,
  output logic [AW-1:0]       pc_q,
  output logic [1:0][1:0]     mode_q,
  output logic [1:0][AW-1:0]  raw_q,
  input  logic [1:0][AW-1:0]  ptr,
  input  logic [1:0][AW-1:0]  dec_word,
  input  logic [1:0][AW-1:0]  result,
  input  logic [1:0]          is_imm,
  output logic                busy,
  output logic                done,
  output logic [AW-1:0]       out_a,
  output logic                imm_a,
  output logic [AW-1:0]       out_b,
  output logic                imm_b,
  output logic                mem_rd_en,
  output logic                mem_wr_en,
  output logic [AW-1:0]       mem_addr,
  output logic [AW-1:0]       mem_wdata
);
  localparam logic [AW:0] N_EXT = (AW+1)'(CORE_SIZE);

  nstate_e       state;
  logic [AW-1:0] res_a_q;
  logic          imm_a_q;

  // named internal events
  logic cur;         // 0: operand A in progress, 1: operand B
  logic addr_phase;
  logic data_phase;
  logic rd_ev;
  logic wr_ev;
  logic op_fin_ev;
  logic a_done_ev;
  logic b_done_ev;

  always_comb begin
    cur        = (state == ST_B_ADDR) || (state == ST_B_DATA);
    addr_phase = (state == ST_A_ADDR) || (state == ST_B_ADDR);
    data_phase = (state == ST_A_DATA) || (state == ST_B_DATA);
    rd_ev      = addr_phase && mode_reads(mode_q[cur]);
    wr_ev      = data_phase && (mode_q[cur] == MODE_PRE);
    op_fin_ev  = (addr_phase && !mode_reads(mode_q[cur])) || data_phase;
    a_done_ev  = op_fin_ev && !cur;
    b_done_ev  = op_fin_ev && cur;
  end

  assign busy      = (state != ST_IDLE);
  assign mem_rd_en = rd_ev;
  assign mem_wr_en = wr_ev;
  assign mem_addr  = ptr[cur];
  assign mem_wdata = dec_word[cur];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pc_q    <= '0;
      mode_q  <= '0;
      raw_q   <= '0;
      res_a_q <= '0;
      imm_a_q <= 1'b0;
      out_a   <= '0;
      imm_a   <= 1'b0;
      out_b   <= '0;
      imm_b   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          pc_q      <= pc_in;
          mode_q[0] <= mode_a_in;
          mode_q[1] <= mode_b_in;
          raw_q[0]  <= raw_a_in;
          raw_q[1]  <= raw_b_in;
          state     <= ST_A_ADDR;
        end
        ST_A_ADDR: state <= mode_reads(mode_q[0]) ? ST_A_DATA : ST_B_ADDR;
        ST_A_DATA: state <= ST_B_ADDR;
        ST_B_ADDR: state <= mode_reads(mode_q[1]) ? ST_B_DATA : ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
      if (a_done_ev) begin
        res_a_q <= result[0];
        imm_a_q <= is_imm[0];
      end
      if (b_done_ev) begin
        out_a <= res_a_q;
        imm_a <= imm_a_q;
        out_b <= result[1];
        imm_b <= is_imm[1];
        done  <= 1'b1;
      end
    end
  end

  // write-back lands on the address read in the previous cycle
  assert_wr_after_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |-> ($past(rd_ev) && $stable(mem_addr)));

  assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ev && wr_ev));

  // B starts only right after A has finished
  assert_a_before_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_B_ADDR) && ($past(state) != ST_B_ADDR)) |-> $past(a_done_ev));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(pc_q) && $stable(mode_q) && $stable(raw_q)));

  assert_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !imm_a) |-> ({1'b0, out_a} < N_EXT));

  assert_in_range_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !imm_b) |-> ({1'b0, out_b} < N_EXT));
endmodule

// File: rtl/operand_normaliser.sv
module operand_normaliser
  import norm_pkg::*;
#(
  parameter int CORE_SIZE = 8000,
  localparam int AW = $clog2(CORE_SIZE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] pc,
  input  logic [1:0]    mode_a,
  input  logic [AW-1:0] raw_a,
  input  logic [1:0]    mode_b,
  input  logic [AW-1:0] raw_b,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] out_a,
  output logic          imm_a,
  output logic [AW-1:0] out_b,
  output logic          imm_b,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata
);
  logic [AW-1:0]      pc_q;
  logic [1:0][1:0]    mode_q;
  logic [1:0][AW-1:0] raw_q;
  logic [1:0][AW-1:0] ptr_w;
  logic [1:0][AW-1:0] dec_w;
  logic [1:0][AW-1:0] res_w;
  logic [1:0]         imm_w;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    norm_eval #(.CORE_SIZE(CORE_SIZE)) u_eval (
      .pc       (pc_q),
      .mode     (amode_e'(mode_q[g])),
      .raw      (raw_q[g]),
      .rdata    (mem_rdata),
      .ptr      (ptr_w[g]),
      .dec_word (dec_w[g]),
      .result   (res_w[g]),
      .is_imm   (imm_w[g])
    );
  end

  norm_ctrl #(.CORE_SIZE(CORE_SIZE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pc_in     (pc),
    .mode_a_in (mode_a),
    .raw_a_in  (raw_a),
    .mode_b_in (mode_b),
    .raw_b_in  (raw_b),
    .pc_q      (pc_q),
    .mode_q    (mode_q),
    .raw_q     (raw_q),
    .ptr       (ptr_w),
    .dec_word  (dec_w),
    .result    (res_w),
    .is_imm    (imm_w),
    .busy      (busy),
    .done      (done),
    .out_a     (out_a),
    .imm_a     (imm_a),
    .out_b     (out_b),
    .imm_b     (imm_b),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );
endmodule

// File: tb/sim_operand_normaliser.sv
`timescale 1ns/1ps
module sim_operand_normaliser;
  localparam int N  = 8000;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] pc = '0, raw_a = '0, raw_b = '0;
  logic [1:0]    mode_a = '0, mode_b = '0;
  logic          busy, done, imm_a, imm_b, mem_rd_en, mem_wr_en;
  logic [AW-1:0] out_a, out_b, mem_addr, mem_wdata;
  logic [AW-1:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int dut_mem[int];
  int ref_mem[int];

  always #10 clk = ~clk;  // 50 MHz

  operand_normaliser #(.CORE_SIZE(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pc(pc),
    .mode_a(mode_a), .raw_a(raw_a), .mode_b(mode_b), .raw_b(raw_b),
    .busy(busy), .done(done), .out_a(out_a), .imm_a(imm_a),
    .out_b(out_b), .imm_b(imm_b), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // core model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= AW'(dut_mem.exists(int'(mem_addr)) ? dut_mem[int'(mem_addr)] : 0);
    if (mem_wr_en) dut_mem[int'(mem_addr)] = int'(mem_wdata);
  end

  function automatic int wrapn(input int x);
    return ((x % N) + N) % N;
  endfunction

  function automatic int ref_get(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setm(input int a, input int v);
    dut_mem[a] = v;
    ref_mem[a] = v;
  endtask

  // expected per-cycle memory trace
  bit q_rd[$];
  bit q_wr[$];
  int q_addr[$];
  int q_wd[$];

  task automatic push_cyc(input bit r, input bit w, input int a, input int d);
    q_rd.push_back(r); q_wr.push_back(w); q_addr.push_back(a); q_wd.push_back(d);
  endtask

  task automatic model_opnd(input int p, input int m, input int v, output int res, output int imm);
    int ptr, rd;
    imm = (m == 0) ? 1 : 0;
    ptr = wrapn(p + v);
    case (m)
      0: begin res = v; push_cyc(0, 0, 0, 0); end
      1: begin res = ptr; push_cyc(0, 0, 0, 0); end
      2: begin
        rd = ref_get(ptr);
        push_cyc(1, 0, ptr, 0);
        push_cyc(0, 0, 0, 0);
        res = wrapn(p + rd);
      end
      default: begin
        rd = wrapn(ref_get(ptr) - 1);
        ref_mem[ptr] = rd;
        push_cyc(1, 0, ptr, 0);
        push_cyc(0, 1, ptr, rd);
        res = wrapn(p + rd);
      end
    endcase
  endtask

  task automatic run(input string tag, input int p, input int ma, input int va,
                     input int mb, input int vb, input bit poke);
    int ea, eb, ia, ib, n;
    q_rd.delete(); q_wr.delete(); q_addr.delete(); q_wd.delete();
    model_opnd(p, ma, va, ea, ia);
    model_opnd(p, mb, vb, eb, ib);
    n = q_rd.size();
    @(negedge clk);
    pc = AW'(p); mode_a = 2'(ma); raw_a = AW'(va); mode_b = 2'(mb); raw_b = AW'(vb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 1) start = 1'b0;
      chk({tag, " R6 rd_en"}, int'(mem_rd_en), int'(q_rd[i]));
      chk({tag, " R5 wr_en"}, int'(mem_wr_en), int'(q_wr[i]));
      if (q_rd[i] || q_wr[i]) chk({tag, " R4 addr"}, int'(mem_addr), q_addr[i]);
      if (q_wr[i]) chk({tag, " R5 wdata"}, int'(mem_wdata), q_wd[i]);
      chk({tag, " R7 done early"}, int'(done), 0);
      if (i == 0 && poke) begin  // R8: second start while busy
        start = 1'b1; pc = AW'(wrapn(p + 777)); mode_a = 2'b11; raw_a = AW'(1);
        mode_b = 2'b00; raw_b = AW'(5);
      end
    end
    @(negedge clk);
    chk({tag, " R7 done"}, int'(done), 1);
    chk({tag, " R2R3 out_a"}, int'(out_a), ea);
    chk({tag, " R2R3 out_b"}, int'(out_b), eb);
    chk({tag, " R2 imm_a"}, int'(imm_a), ia);
    chk({tag, " R2 imm_b"}, int'(imm_b), ib);
    chk({tag, " R8 busy clear"}, int'(busy), 0);
    @(negedge clk);
    chk({tag, " R7 pulse"}, int'(done), 0);
    chk({tag, " R7 hold a"}, int'(out_a), ea);
    chk({tag, " R7 hold b"}, int'(out_b), eb);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 rd after reset", int'(mem_rd_en), 0);
    chk("R1 wr after reset", int'(mem_wr_en), 0);
    chk("R1 busy after reset", int'(busy), 0);

    run("R2 imm/imm", 100, 0, 55, 0, 7999, 0);
    run("R3 R9 dir wrap", 7990, 1, 20, 1, 0, 0);
    setm(510, 300);
    run("R4 ind/dir", 500, 2, 10, 1, 3, 0);
    setm(1005, 0);
    run("R5 R6 pre zero then ind", 1000, 3, 5, 2, 5, 0);
    setm(2050, 4);
    run("R6 pre/pre same", 2000, 3, 50, 3, 50, 0);
    setm(3003, 12);
    run("R8 busy start", 3000, 1, 9, 3, 3, 1);
    setm(5, 7000);
    run("R9 ind wrap", 7995, 2, 10, 0, 123, 0);
    run("R3 self", 42, 1, 0, 2, 0, 0);

    finished = 1;
    report();
    $finish;
  end
endmodule